// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

This block is an independent watchdog. Its 12-bit counter runs from a separate low-speed clock and fires a one-cycle reset pulse in that clock's domain when it expires. Software never writes the counter directly. Every action goes through a key register on the bus clock side. One key value starts the watchdog, one refreshes it, and one opens the three configuration registers: prescaler code, reload value and window limit. Any other key closes them again.

A configuration write is posted. The bus side keeps the new value in a shadow register and raises a pending flag for that register. The value then crosses into the slow domain through a toggle handshake, and the flag drops once the slow side has acknowledged it. A refresh that comes while the counter is still above the window limit counts as premature and fires a reset at once. Writing the window register reloads the counter by itself. A freeze input, which is synchronous to the slow clock, holds the count while the core is halted.

Top module: `keyed_window_wdt`

## Requirements
- R1: Key 0x0000CCCC starts the watchdog. The counter then counts down from 0xFFF, and a reset pulse comes 4096 ticks after start. No pulse ever comes before the start key has been written.
- R2: Key 0x0000AAAA loads the reload value into the counter. With reload value R and divide ratio D, the next expiry pulse comes (R+1)*D slow-clock cycles after the refresh takes effect.
- R3: Key 0x00005555 opens the prescaler (address 1), reload (address 2) and window (address 3) registers. Any other key value written to address 0 closes them. A write to any of the three while closed leaves its read-back value unchanged.
- R4: Status (address 4) bit 0 flags a pending prescaler transfer, bit 1 a pending reload transfer and bit 2 a pending window transfer. A flag is set from the cycle after an accepted write and clears within a few slow-clock cycles. A write to a register whose flag is set is ignored.
- R5: The 3-bit prescaler code c selects a divide ratio of 4<<c for c = 0 to 5. Codes 6 and 7 both select 256.
- R6: The window register resets to 0xFFF. A refresh key that arrives while the counter is above the window value fires a reset pulse within a few slow cycles.
- R7: When a new window value arrives in the slow domain, the counter is loaded with the reload value.
- R8: While freeze is high, the counter and the prescaler hold. Refresh and window loads still take effect.
- R9: Once started, the watchdog keeps running whatever keys are written afterwards.
- R10: The reset pulse is exactly one slow-clock cycle wide.
- R11: After reset the block reads prescaler 0, reload 0xFFF, window 0xFFF and status 0, and reset_pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| slow_clk | input | 1 | Low-speed counter clock |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 3 | Register address: 0 key, 1 prescaler, 2 reload, 3 window, 4 status |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Read data for addr, combinational |
| freeze | input | 1 | Halts counting while high, synchronous to slow_clk |
| reset_pulse | output | 1 | Watchdog reset, one slow-clock cycle |

## Verification
The bench times each expiry interval against a narrow bound. A prescaler table off by one step, a counter that starts from the reload value instead of 0xFFF, or a window write that does not reload would all land outside it. It writes a second value straight behind the first one while the first is still pending, and checks read-back. A design that lets the second write through would show the wrong value. It also writes a stray key between the unlock key and a configuration write, to catch a lock that does not close again. The window case refreshes once too early and once late. Skipping the violation pulse, or firing on a legal refresh, both show up at reset_pulse.

// File: rtl/wdt_pkg.sv
// Shared constants for the keyed watchdog: key codes, register addresses,
// configuration channel indices and the prescaler ratio lookup.
package wdt_pkg;
    localparam logic [31:0] KEY_REFRESH = 32'h0000_AAAA;
    localparam logic [31:0] KEY_UNLOCK  = 32'h0000_5555;
    localparam logic [31:0] KEY_START   = 32'h0000_CCCC;

    localparam int AW = 3;
    localparam logic [AW-1:0] A_KEY  = 3'd0;
    localparam logic [AW-1:0] A_DIV  = 3'd1;
    localparam logic [AW-1:0] A_RLD  = 3'd2;
    localparam logic [AW-1:0] A_WIN  = 3'd3;
    localparam logic [AW-1:0] A_STAT = 3'd4;

    localparam int NCFG   = 3;
    localparam int CH_DIV = 0;
    localparam int CH_RLD = 1;
    localparam int CH_WIN = 2;

    localparam int PSC_W   = 3;
    localparam int PSC_MAX = 256;
    localparam int PW      = $clog2(PSC_MAX);

    // Divide ratio for a prescaler code: 4<<code, saturating at 256.
    function automatic logic [PW:0] div_of(input logic [PSC_W-1:0] code);
        if (code >= 3'd6) return (PW+1)'(PSC_MAX);
        return (PW+1)'(4) << code;
    endfunction
endpackage

// File: rtl/wdt_sync.sv
// Two-flop level synchronizer for a vector of independent bits.
// Assumes each bit is a level or a toggle that is held for several
// destination cycles, so bits are never required to arrive together.
module wdt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wdt_bus_side.sv
// Bus-clock half of the watchdog: key decode, lock state, start latch,
// refresh toggle, and one posted shadow register per configuration channel
// with its pending flag and request toggle.
// Assumes ack_sync returns each request toggle after the slow side captured
// the shadow value; the shadow is frozen while its flag is set.
module wdt_bus_side
    import wdt_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    output logic [NCFG-1:0][CW-1:0]  cfg_val,
    output logic [NCFG-1:0]          req_tgl,
    input  logic [NCFG-1:0]          ack_sync,
    output logic                     rfr_tgl,
    output logic                     started
);
    logic                unlocked;
    logic [NCFG-1:0]     pend;
    logic                key_wr;

    assign key_wr = wr_en && (addr == A_KEY);

    // Key register: lock state, sticky start, refresh event toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            started  <= 1'b0;
            rfr_tgl  <= 1'b0;
        end else if (key_wr) begin
            unlocked <= (wdata == KEY_UNLOCK);
            if (wdata == KEY_START)   started <= 1'b1;
            if (wdata == KEY_REFRESH) rfr_tgl <= ~rfr_tgl;
        end
    end

    for (genvar g = 0; g < NCFG; g++) begin : g_chan
        localparam logic [CW-1:0] RST_VAL = (g == CH_DIV) ? '0 : '1;
        logic [CW-1:0] shadow_q;
        logic          pend_q;
        logic          req_q;
        logic          hit;

        assign hit = wr_en && unlocked && !pend_q && (addr == A_DIV + AW'(g));

        // Posted write: capture value, raise pending, flip request; drop on ack.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= RST_VAL;
                pend_q   <= 1'b0;
                req_q    <= 1'b0;
            end else if (hit) begin
                if (g == CH_DIV) shadow_q <= CW'(wdata[PSC_W-1:0]);
                else             shadow_q <= wdata[CW-1:0];
                pend_q   <= 1'b1;
                req_q    <= ~req_q;
            end else if (pend_q && (ack_sync[g] == req_q)) begin
                pend_q   <= 1'b0;
            end
        end

        assign cfg_val[g] = shadow_q;
        assign pend[g]    = pend_q;
        assign req_tgl[g] = req_q;
    end

    // Read mux over shadows and status.
    always_comb begin
        rdata = '0;
        case (addr)
            A_DIV:   rdata[CW-1:0]   = cfg_val[CH_DIV];
            A_RLD:   rdata[CW-1:0]   = cfg_val[CH_RLD];
            A_WIN:   rdata[CW-1:0]   = cfg_val[CH_WIN];
            A_STAT:  rdata[NCFG-1:0] = pend;
            default: rdata = '0;
        endcase
    end

    // R3: closed registers keep their value when written.
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked && addr == A_RLD) |=> $stable(cfg_val[CH_RLD]));

    // R4: a pending register cannot change.
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend[CH_WIN] |=> $stable(cfg_val[CH_WIN]));

    // R9: start can never be undone.
    p_start_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        started |=> started);
endmodule

// File: rtl/wdt_slow_core.sv
// Slow-clock half of the watchdog: captures posted configuration on request
// toggle edges, returns acknowledges, runs the prescaler and the 12-bit down
// counter, applies refresh and window-reload events, and issues the pulse.
// Assumes all request inputs are already synchronized to slow_clk and that
// cfg_val is stable whenever its request toggle differs from the local copy.
module wdt_slow_core
    import wdt_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                     slow_clk,
    input  logic                     rst_n,
    input  logic [NCFG-1:0][CW-1:0]  cfg_val,
    input  logic [NCFG-1:0]          req_s,
    input  logic                     rfr_s,
    input  logic                     run,
    input  logic                     freeze,
    output logic [NCFG-1:0]          ack_tgl,
    output logic                     reset_pulse
);
    logic [NCFG-1:0]  req_d;
    logic             rfr_d;
    logic [NCFG-1:0]  cap;
    logic             rfr_ev;
    logic [PSC_W-1:0] div_q;
    logic [CW-1:0]    rld_q;
    logic [CW-1:0]    win_q;
    logic [CW-1:0]    cnt_q;
    logic [PW-1:0]    pcnt_q;
    logic [PW-1:0]    lim;
    logic [PSC_W-1:0] div_in;
    logic             fire;

    assign cap     = req_s ^ req_d;
    assign rfr_ev  = rfr_s ^ rfr_d;
    assign ack_tgl = req_d;
    assign lim     = PW'(div_of(div_q) - 1'b1);
    // Out-of-range upper bits saturate to the largest ratio.
    assign div_in  = (|cfg_val[CH_DIV][CW-1:PSC_W]) ? '1 : cfg_val[CH_DIV][PSC_W-1:0];

    // Edge trackers for request and refresh toggles.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) begin
            req_d <= '0;
            rfr_d <= 1'b0;
        end else begin
            req_d <= req_s;
            rfr_d <= rfr_s;
        end
    end

    // Capture posted configuration values on their request edges.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) begin
            div_q <= '0;
            rld_q <= '1;
            win_q <= '1;
        end else begin
            if (cap[CH_DIV]) div_q <= div_in;
            if (cap[CH_RLD]) rld_q <= cfg_val[CH_RLD];
            if (cap[CH_WIN]) win_q <= cfg_val[CH_WIN];
        end
    end

    // Counter, prescaler and reset request; loads win over ticks.
    always_comb begin
        fire = 1'b0;
        if (run && (rfr_ev || cap[CH_WIN]))
            fire = rfr_ev && (cnt_q > win_q);
        else if (run && !freeze && pcnt_q == lim && cnt_q == '0)
            fire = 1'b1;
    end

    // Advance prescaler and counter, or reload on an event.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            pcnt_q <= '0;
        end else if (run && (rfr_ev || cap[CH_WIN])) begin
            cnt_q  <= rld_q;
            pcnt_q <= '0;
        end else if (run && !freeze) begin
            if (pcnt_q == lim) begin
                pcnt_q <= '0;
                cnt_q  <= (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    // Single-cycle reset pulse register.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) reset_pulse <= 1'b0;
        else        reset_pulse <= fire && !reset_pulse;
    end

    // R1: nothing fires before start.
    p_quiet_before_start_r1: assert property (@(posedge slow_clk) disable iff (!rst_n)
        !run |=> !reset_pulse);

    // R2: a refresh loads the reload value.
    p_refresh_loads_r2: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (run && rfr_ev) |=> cnt_q == $past(rld_q));

    // R6: premature refresh fires.
    p_window_violation_r6: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (run && rfr_ev && cnt_q > win_q && !reset_pulse) |=> reset_pulse);

    // R7: a new window value reloads the counter.
    p_window_reload_r7: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (run && cap[CH_WIN]) |=> cnt_q == $past(rld_q));

    // R8: freeze holds count and prescaler when no load is due.
    p_freeze_hold_r8: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (freeze && !rfr_ev && !cap[CH_WIN]) |=> ($stable(cnt_q) && $stable(pcnt_q)));

    // R10: pulse lasts one cycle.
    p_pulse_width_r10: assert property (@(posedge slow_clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse);
endmodule

// File: rtl/keyed_window_wdt.sv
// Top of the keyed windowed watchdog: bus-side register file, two
// synchronizer banks (requests toward the slow clock, acknowledges back),
// and the slow-clock counter core.
// Assumes rst_n is held low for several slow_clk cycles.
module keyed_window_wdt
    import wdt_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_clk,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic          freeze,
    output logic          reset_pulse
);
    localparam int XW = NCFG + 2;

    logic [NCFG-1:0][CW-1:0] cfg_val;
    logic [NCFG-1:0]         req_tgl;
    logic [NCFG-1:0]         ack_tgl;
    logic [NCFG-1:0]         ack_sync;
    logic                    rfr_tgl;
    logic                    started;
    logic [XW-1:0]           fwd_s;

    wdt_bus_side #(.CW(CW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .cfg_val  (cfg_val),
        .req_tgl  (req_tgl),
        .ack_sync (ack_sync),
        .rfr_tgl  (rfr_tgl),
        .started  (started)
    );

    wdt_sync #(.W(XW)) u_fwd (
        .clk   (slow_clk),
        .rst_n (rst_n),
        .d     ({started, rfr_tgl, req_tgl}),
        .q     (fwd_s)
    );

    wdt_sync #(.W(NCFG)) u_back (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_sync)
    );

    wdt_slow_core #(.CW(CW)) u_core (
        .slow_clk    (slow_clk),
        .rst_n       (rst_n),
        .cfg_val     (cfg_val),
        .req_s       (fwd_s[NCFG-1:0]),
        .rfr_s       (fwd_s[NCFG]),
        .run         (fwd_s[NCFG+1]),
        .freeze      (freeze),
        .ack_tgl     (ack_tgl),
        .reset_pulse (reset_pulse)
    );
endmodule

// File: tb/sim_keyed_window_wdt.sv
module sim_keyed_window_wdt;
    logic        clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        freeze = 1'b0;
    logic        reset_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int lcyc = 0;
    int npulse = 0;
    int tlast = 0;
    int wide = 0;
    logic prev_p = 1'b0;

    always #2 clk = ~clk;        // 250 MHz
    always #8 slow_clk = ~slow_clk;

    keyed_window_wdt u0 (.clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .freeze(freeze), .reset_pulse(reset_pulse));

    always @(posedge slow_clk) lcyc <= lcyc + 1;

    // Pulse monitor, sampled mid-cycle.
    always @(negedge slow_clk) begin
        if (reset_pulse) begin
            npulse = npulse + 1;
            tlast = lcyc;
            if (prev_p) wide = wide + 1;
        end
        prev_p = reset_pulse;
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic slow_wait(input int n);
        repeat (n) @(posedge slow_clk);
    endtask

    // Write a key then return the interval to the first pulse after it.
    task automatic key_to_pulse(input logic [31:0] key, input int limit, output int dt);
        int n0, t0;
        n0 = npulse;
        wr(3'd0, key);
        t0 = lcyc;
        while (npulse == n0 && lcyc < t0 + limit) @(posedge slow_clk);
        @(negedge slow_clk);
        dt = (npulse == n0) ? -1 : tlast - t0;
    endtask

    task automatic cfg(input logic [2:0] a, input logic [31:0] d);
        wr(3'd0, 32'h5555);
        wr(a, d);
        slow_wait(25);
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        rd(3'd1, v); check("R11 div", v, 0);
        rd(3'd2, v); check("R11 reload", v, 12'hFFF);
        rd(3'd3, v); check("R11 window", v, 12'hFFF);
        check("R6 window reset value", v, 12'hFFF);
        rd(3'd4, v); check("R11 status", v, 0);
        check("R11 no pulse", npulse, 0);
    endtask

    task automatic t_lock;
        logic [31:0] v;
        wr(3'd2, 32'h111); slow_wait(25);
        rd(3'd2, v); check("R3 locked after reset", v, 12'hFFF);
        wr(3'd0, 32'h5555); wr(3'd0, 32'h1234); wr(3'd2, 32'h222); slow_wait(25);
        rd(3'd2, v); check("R3 relock by other key", v, 12'hFFF);
        wr(3'd0, 32'h5555); wr(3'd2, 32'h333); slow_wait(25);
        rd(3'd2, v); check("R3 unlocked write", v, 12'h333);
    endtask

    task automatic t_pending;
        logic [31:0] v;
        wr(3'd0, 32'h5555);
        wr(3'd2, 32'h0AB);
        wr(3'd2, 32'h0CD);
        rd(3'd4, v); check("R4 reload pending flag", v, 3'b010);
        slow_wait(25);
        rd(3'd4, v); check("R4 flag clears", v, 0);
        rd(3'd2, v); check("R4 write while pending ignored", v, 12'h0AB);
        check("R1 no pulse before start", npulse, 0);
    endtask

    task automatic t_start;
        int dt;
        key_to_pulse(32'hCCCC, 16500, dt);
        check_rng("R1 start expiry from 0xFFF", dt, 16384, 16394);
    endtask

    task automatic t_refresh;
        int dt;
        cfg(3'd2, 32'd20);
        wr(3'd0, 32'hAAAA); slow_wait(8);
        key_to_pulse(32'hAAAA, 300, dt);
        check_rng("R2 refresh expiry R=20 D=4", dt, 84, 94);
    endtask

    task automatic t_sticky;
        int n0;
        wr(3'd0, 32'h0); wr(3'd0, 32'h5555); wr(3'd0, 32'h1);
        n0 = npulse;
        slow_wait(200);
        check("R9 still running after other keys", npulse > n0, 1);
    endtask

    task automatic t_prescale(input logic [2:0] code, input int ratio);
        int dt;
        cfg(3'd1, {29'd0, code});
        wr(3'd0, 32'hAAAA); slow_wait(8);
        key_to_pulse(32'hAAAA, 21 * ratio + 40, dt);
        check_rng($sformatf("R5 prescaler code %0d", code), dt, 21 * ratio, 21 * ratio + 10);
    endtask

    task automatic t_freeze;
        int n0, t0;
        cfg(3'd1, 32'd0);
        @(negedge slow_clk); freeze = 1'b1;
        slow_wait(2);
        n0 = npulse;
        wr(3'd0, 32'hAAAA);
        slow_wait(400);
        check("R8 no expiry while frozen", npulse, n0);
        @(negedge slow_clk); freeze = 1'b0; t0 = lcyc;
        while (npulse == n0 && lcyc < t0 + 300) @(posedge slow_clk);
        @(negedge slow_clk);
        check_rng("R8 resumes after freeze", (npulse == n0) ? -1 : tlast - t0, 84, 92);
    endtask

    task automatic t_window;
        int dt, n0;
        cfg(3'd2, 32'd40);
        wr(3'd0, 32'hAAAA); slow_wait(10);
        wr(3'd0, 32'h5555);
        n0 = npulse;
        wr(3'd3, 32'd10);
        begin
            int t0;
            t0 = lcyc;
            while (npulse == n0 && lcyc < t0 + 400) @(posedge slow_clk);
            @(negedge slow_clk);
            dt = (npulse == n0) ? -1 : tlast - t0;
        end
        check_rng("R7 window write reloads counter", dt, 164, 174);
        slow_wait(3);
        key_to_pulse(32'hAAAA, 40, dt);
        check_rng("R6 early refresh fires", dt, 0, 8);
        slow_wait(140 - dt);
        n0 = npulse;
        wr(3'd0, 32'hAAAA);
        slow_wait(20);
        check("R6 refresh inside window is quiet", npulse, n0);
    endtask

    initial begin
        repeat (20) @(posedge slow_clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset_state();
        t_lock();
        t_pending();
        t_start();
        t_refresh();
        t_sticky();
        t_prescale(3'd2, 16);
        t_prescale(3'd7, 256);
        t_freeze();
        t_window();
        check("R10 single-cycle pulses", wide, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule